// File: doc/BRIEF.md
# Sleep-State Sequencer for a Synchronous SRAM

This block sits beside a synchronous SRAM core and manages a low-power hold state. A sleep request arrives on an asynchronous, active-high pin; an undriven pin is taken as low, which means normal operation. The request is brought into the clock domain through a flop synchroniser. The block then counts a fixed entry delay before declaring sleep, and a fixed recovery delay after the request is removed before declaring the device usable again.

While the block is entering sleep, is asleep, or is recovering, it raises a hold signal. That signal gates every array access, so stored words are never disturbed, and it keeps the data bus drivers off. Current reduction in the array is outside this block; the hold signal stands in for it.

The block also qualifies address strobes against the three chip selects. It reports an access that was still in flight at the moment sleep took effect; such an access counts as invalid. It keeps a sticky error flag for any strobe accepted during sleep or recovery, and that strobe is dropped. All pins are plain level control and status signals. No data path passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, `sleep_active`, `core_hold`, `pend_drop` and `viol_flag` are low, and the synchroniser holds the idle (low) request level.
- R2: The request passes through two flops, and entry then takes two further cycles. If `sleep_req` is first sampled high at rising edge n, `sleep_active` rises after edge n+4, provided the request was sampled high at edges n, n+1 and n+2. A request sampled high on fewer than three consecutive edges never sets `sleep_active`.
- R3: If the request is first sampled low at edge m while asleep, `sleep_active` falls after edge m+4. If the request is sampled high again before then, the device goes back to sleep and `sleep_active` never drops. For a request held high across exactly L ≥ 3 edges, `sleep_active` is therefore high for L cycles.
- R4: `pend_drop` is high for exactly one cycle, the first cycle of `sleep_active`, when `acc_pending` was high at the edge that entered sleep. Otherwise it stays low.
- R5: An access is taken when `cs_a`, `cs_b` and `cs_c` are all high and either `strb_ctl` is high or `strb_cpu` is high. The processor strobe counts only with `cs_a` high. `access_grant` equals this condition while `core_hold` is low, and is low while `core_hold` is high.
- R6: `core_hold`, which gates the array and keeps the data bus tri-stated, is high from the edge after the first synchronised request sample (edge n+2) until `sleep_active` falls, or until the entry is abandoned. For a request held across L edges it is high for L+2 cycles if L ≥ 3, and for L cycles otherwise.
- R7: `viol_flag` rises after any edge at which an access (as in R5) is presented while `sleep_active` is high. It then stays high until reset. Strobes without full chip selects leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cs_a | input | 1 | Chip select A, active high; also qualifies the processor strobe |
| cs_b | input | 1 | Chip select B, active high |
| cs_c | input | 1 | Chip select C, active high |
| strb_cpu | input | 1 | Processor address strobe, active high |
| strb_ctl | input | 1 | Controller address strobe, active high |
| acc_pending | input | 1 | Core reports an access still in progress |
| sleep_active | output | 1 | Asleep or in the recovery window |
| core_hold | output | 1 | Blocks array access and forces the data bus to high impedance |
| access_grant | output | 1 | Qualified access allowed to reach the core |
| pend_drop | output | 1 | One-cycle mark: an in-flight access was invalidated by sleep entry |
| viol_flag | output | 1 | Sticky: an access was attempted during sleep or recovery |

## Verification
`access_grant` is combinational, so it is checked one time unit after each input change, within the same cycle. `sleep_active` and `core_hold` are due four and two edges after the first request sample. The bench drives the request at a falling edge and records which cycle each output first and last reads high. It compares those indices, and the high-cycle counts for every pulse length from one to eight cycles, with the arithmetic values in R2, R3 and R6. `viol_flag` and `pend_drop` are registered and are read at the falling edge after the edge that captures their cause.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output slp_state_e state,
  output logic       enter_now
);
  localparam int MAXC  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LD = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);

  slp_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_AWAKE:
          if (req_s) begin
            st_q  <= ST_ENTER;
            cnt_q <= ENTRY_LD;
          end
        ST_ENTER:
          if (!req_s)           st_q  <= ST_AWAKE;
          else if (cnt_q == '0) st_q  <= ST_ASLEEP;
          else                  cnt_q <= cnt_q - 1'b1;
        ST_ASLEEP:
          if (!req_s) begin
            st_q  <= ST_RECOVER;
            cnt_q <= EXIT_LD;
          end
        default:
          if (req_s)            st_q  <= ST_ASLEEP;
          else if (cnt_q == '0) st_q  <= ST_AWAKE;
          else                  cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign state     = st_q;
  assign enter_now = (st_q == ST_ENTER) && req_s && (cnt_q == '0);
endmodule

// File: rtl/slp_guard.sv
module slp_guard
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state,
  input  logic       enter_now,
  input  logic       cs_a,
  input  logic       cs_b,
  input  logic       cs_c,
  input  logic       strb_cpu,
  input  logic       strb_ctl,
  input  logic       acc_pending,
  output logic       hold,
  output logic       asleep,
  output logic       grant,
  output logic       pend,
  output logic       viol
);
  logic sel_all, strobe_ok, take;
  logic pend_q, viol_q;

  assign sel_all   = cs_a & cs_b & cs_c;
  assign strobe_ok = (strb_cpu & cs_a) | strb_ctl;
  assign take      = sel_all & strobe_ok;
  assign hold      = (state != ST_AWAKE);
  assign asleep    = (state == ST_ASLEEP) || (state == ST_RECOVER);
  assign grant     = take & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      pend_q <= enter_now & acc_pending;
      viol_q <= viol_q | (take & asleep);
    end
  end

  assign pend = pend_q;
  assign viol = viol_q;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic cs_a,
  input  logic cs_b,
  input  logic cs_c,
  input  logic strb_cpu,
  input  logic strb_ctl,
  input  logic acc_pending,
  output logic sleep_active,
  output logic core_hold,
  output logic access_grant,
  output logic pend_drop,
  output logic viol_flag
);
  logic       req_s;
  logic       enter_now;
  slp_state_e state;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_req), .q_sync(req_s)
  );

  slp_seq #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .state(state), .enter_now(enter_now)
  );

  slp_guard u_guard (
    .clk(clk), .rst_n(rst_n), .state(state), .enter_now(enter_now),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
    .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .acc_pending(acc_pending),
    .hold(core_hold), .asleep(sleep_active), .grant(access_grant),
    .pend(pend_drop), .viol(viol_flag)
  );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_a,
  input logic cs_b,
  input logic cs_c,
  input logic strb_cpu,
  input logic strb_ctl,
  input logic sleep_active,
  input logic core_hold,
  input logic access_grant,
  input logic pend_drop,
  input logic viol_flag
);
  AST_NO_GRANT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold |-> !access_grant); // R5
  AST_HOLD_COVERS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> core_hold); // R6
  AST_SLEEP_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |=> sleep_active); // R3
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |=> viol_flag); // R7
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(sleep_active && cs_a && cs_b && cs_c
                               && (strb_cpu || strb_ctl))); // R7
  AST_PEND_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_drop |-> $rose(sleep_active)); // R4
  AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_drop |=> !pend_drop); // R4
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
  .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .sleep_active(sleep_active),
  .core_hold(core_hold), .access_grant(access_grant),
  .pend_drop(pend_drop), .viol_flag(viol_flag)
);

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic cs_a = 1'b0, cs_b = 1'b0, cs_c = 1'b0;
  logic strb_cpu = 1'b0, strb_ctl = 1'b0, acc_pending = 1'b0;
  logic sleep_active, core_hold, access_grant, pend_drop, viol_flag;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
    .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .acc_pending(acc_pending),
    .sleep_active(sleep_active), .core_hold(core_hold),
    .access_grant(access_grant), .pend_drop(pend_drop), .viol_flag(viol_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_bus(input logic [4:0] v);
    {cs_a, cs_b, cs_c, strb_cpu, strb_ctl} = v;
  endtask

  function automatic int take_of(input logic [4:0] v);
    return (v[4] && v[3] && v[2] && (v[0] || (v[1] && v[4]))) ? 1 : 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    sleep_req = 1'b0;
    set_bus(5'd0);
    acc_pending = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 sleep_active", sleep_active, 0);
    chk("R1 core_hold", core_hold, 0);
    chk("R1 pend_drop", pend_drop, 0);
    chk("R1 viol_flag", viol_flag, 0);

    // R5 awake: grant over every strobe/select combination
    for (int v = 0; v < 32; v++) begin
      set_bus(v[4:0]);
      #1;
      chk("R5 grant awake", access_grant, take_of(v[4:0]));
    end
    set_bus(5'd0);

    // R2 R3 R4 R6 pulse length sweep
    for (int L = 1; L <= 8; L++) begin
      int first_hi, first_lo, n_sl, n_hold, n_pend, pend_at;
      first_hi = -1; first_lo = -1; n_sl = 0; n_hold = 0; n_pend = 0; pend_at = -1;
      acc_pending = L[0];
      sleep_req = 1'b1;
      for (int c = 0; c < L + 16; c++) begin
        @(posedge clk); @(negedge clk);
        if (c == L - 1) sleep_req = 1'b0;
        if (sleep_active) begin
          n_sl++;
          if (first_hi < 0) first_hi = c;
        end else if (first_hi >= 0 && first_lo < 0) first_lo = c;
        if (core_hold) n_hold++;
        if (pend_drop) begin n_pend++; pend_at = c; end
      end
      acc_pending = 1'b0;
      chk("R2 sleep cycles", n_sl, (L >= 3) ? L : 0);
      chk("R2 entry edge", first_hi, (L >= 3) ? 4 : -1);
      chk("R3 exit edge", first_lo, (L >= 3) ? L + 4 : -1);
      chk("R6 hold cycles", n_hold, (L >= 3) ? L + 2 : L);
      chk("R4 pend count", n_pend, (L >= 3 && L[0]) ? 1 : 0);
      chk("R4 pend cycle", pend_at, (L >= 3 && L[0]) ? 4 : -1);
    end

    // R3 request returns inside the recovery window
    begin
      int fell;
      fell = 0;
      sleep_req = 1'b1;
      for (int c = 0; c < 24; c++) begin
        @(posedge clk); @(negedge clk);
        if (c == 4) sleep_req = 1'b0;
        if (c == 5) sleep_req = 1'b1;
        if (c >= 4 && !sleep_active) fell = 1;
      end
      chk("R3 re-entry keeps sleep", fell, 0);
      sleep_req = 1'b0;
      cycles(8);
      chk("R3 awake after drop", sleep_active, 0);
    end

    // R7 R5 sweep while asleep: flag set by first full access, then sticky
    sleep_req = 1'b1;
    cycles(8);
    chk("R2 asleep", sleep_active, 1);
    begin
      int exp_v;
      exp_v = 0;
      for (int v = 0; v < 32; v++) begin
        set_bus(v[4:0]);
        #1;
        chk("R5 grant asleep", access_grant, 0);
        @(posedge clk); @(negedge clk);
        if (take_of(v[4:0]) != 0) exp_v = 1;
        chk("R7 viol asleep", viol_flag, exp_v);
      end
    end
    set_bus(5'd0);
    sleep_req = 1'b0;
    cycles(8);
    chk("R7 viol sticky", viol_flag, 1);
    chk("R3 awake", sleep_active, 0);
    do_reset();
    chk("R1 viol cleared", viol_flag, 0);

    // R7 partial selects in sleep raise nothing
    sleep_req = 1'b1;
    cycles(8);
    set_bus(5'b01111);
    cycles(1);
    set_bus(5'b11011);
    cycles(1);
    set_bus(5'd0);
    chk("R7 partial select", viol_flag, 0);

    // R7 access inside the recovery window
    sleep_req = 1'b0;
    cycles(3);
    chk("R3 still recovering", sleep_active, 1);
    set_bus(5'b11101);
    #1;
    chk("R5 grant recovering", access_grant, 0);
    cycles(1);
    set_bus(5'd0);
    chk("R7 viol recovery", viol_flag, 1);
    cycles(4);
    set_bus(5'b11110);
    #1;
    chk("R5 grant after exit", access_grant, 1);
    set_bus(5'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule